// File: doc/BRIEF.md
# Two-Wire Bus Controller Control and Status Register File

This block is the register file between a host processor and the protocol engine of a two-wire serial bus controller. The host changes an 8-bit control register only through two write addresses. One address turns on the bits marked by ones in the written value. The other address turns those bits off. Bits written as zero keep their value in both cases. The control bits drive the protocol engine directly. One of them, the interrupt flag, is also the interrupt request line.

When the protocol engine reaches a new bus state, it presents a 5-bit state code with a one-cycle strobe. If the interrupt flag is clear, the block latches the code into the status register and raises the flag. The 5-bit code covers up to 26 states across the four operating modes: master transmit, master receive, slave transmit and slave receive. The status register shows the code in bits 7:3, and its low three bits are always zero. Software can therefore use the status value directly as a table offset, with one entry every eight locations.

While the flag is set, the status register keeps its value. A strobe that arrives during this time is held pending, and it is latched one clock after software clears the flag.

Top module: `sbus_ctlstat_regs`

## Requirements
- R1: After reset the control register and `ctrl_o` are 0x00, `irq_o` is 0, no strobe is pending, and the status register reads 0xF8 (state code 5'h1F).
- R2: A write to address 0 (the set port) makes every control bit that is 1 in the written value equal to 1. All other bits keep their value.
- R3: A write to address 2 (the clear port) makes every control bit that is 1 in the written value equal to 0. All other bits keep their value. A read of address 0 returns the control register. A read of address 2 returns 0x00.
- R4: A read of address 1 returns the status register as {code[4:0], 3'b000}. Bits 2:0 always read as zero.
- R5: A strobe on `core_evt` while the flag (control bit 3) is clear latches `core_code` into the status register and sets the flag at the same clock edge.
- R6: While the flag is set, the status register does not change. A strobe in this time is held pending. If several strobes arrive, the pending code is the one from the most recent strobe.
- R7: When a strobe is pending, the edge that clears the flag leaves the flag at 0 for one cycle. The next edge latches the pending code and sets the flag again. With nothing pending, the flag stays clear.
- R8: `irq_o` is 1 exactly when control bit 3 is 1.
- R9: Writes to address 1 and address 3 change nothing. A read of address 3 returns 0x00. `host_rdata` is 0x00 unless `host_sel` is 1 and `host_we` is 0.
- R10: Suppose a clear-port write that names the flag happens in the same cycle as a strobe that gets latched. The flag ends up set. A set-port write of the flag raises `irq_o` without changing the status code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register address: 0 set port, 1 status, 2 clear port, 3 unused |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| core_code | input | 5 | Bus-state code from the protocol engine |
| core_evt | input | 1 | One-cycle strobe marking a new bus state |
| ctrl_o | output | 8 | Control register contents |
| irq_o | output | 1 | Interrupt request (the flag bit) |

## Verification
The bench builds the block with the flag at bit 3 and an idle code of 5'h1F. With these values the reset status reads 0xF8, and bit 3 of every written mask can be checked against `irq_o`. The vector table writes only masks that leave bit 3 alone, so the plain set and clear behaviour is tested apart from flag handling. The directed tests then cover these cases:
- two strobes arriving while the flag is set;
- the one-cycle gap before a pending code is latched;
- a latched strobe in the same cycle as a clear write.

// File: rtl/sbus_regs_pkg.sv
package sbus_regs_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned CODE_W    = 5;
  localparam int unsigned HOST_AW   = 2;
  localparam int unsigned VEC_SHIFT = DATA_W - CODE_W;

  typedef enum logic [HOST_AW-1:0] {
    REG_CTRL_SET = 2'd0,
    REG_STATUS   = 2'd1,
    REG_CTRL_CLR = 2'd2,
    REG_SPARE    = 2'd3
  } reg_sel_e;

  // Set-then-clear update: clear wins on a shared bit position
  function automatic logic [DATA_W-1:0] setclr_apply(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] set_m,
      input logic [DATA_W-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  // Status word: code in the top bits, zero padding below
  function automatic logic [DATA_W-1:0] status_word(input logic [CODE_W-1:0] code);
    return {code, {VEC_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/sbus_host_dec.sv
module sbus_host_dec
  import sbus_regs_pkg::*;
(
  input  logic                host_sel,
  input  logic                host_we,
  input  logic [HOST_AW-1:0]  host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic [DATA_W-1:0]   ctrl_q,
  input  logic [CODE_W-1:0]   status_code,
  output logic [DATA_W-1:0]   set_mask,
  output logic [DATA_W-1:0]   clr_mask,
  output logic [DATA_W-1:0]   host_rdata
);
  logic wr_en, rd_en;
  reg_sel_e sel_reg;

  assign wr_en   = host_sel & host_we;
  assign rd_en   = host_sel & ~host_we;
  assign sel_reg = reg_sel_e'(host_addr);

  assign set_mask = (wr_en && sel_reg == REG_CTRL_SET) ? host_wdata : '0;
  assign clr_mask = (wr_en && sel_reg == REG_CTRL_CLR) ? host_wdata : '0;

  always_comb begin
    host_rdata = '0;
    if (rd_en) begin
      unique case (sel_reg)
        REG_CTRL_SET: host_rdata = ctrl_q;
        REG_STATUS:   host_rdata = status_word(status_code);
        REG_CTRL_CLR: host_rdata = '0;
        REG_SPARE:    host_rdata = '0;
        default:      host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sbus_ctl_bank.sv
module sbus_ctl_bank
  import sbus_regs_pkg::*;
#(
  parameter int unsigned FLAG_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic              hw_flag_set,
  output logic [DATA_W-1:0] ctrl_q
);
  logic [DATA_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = setclr_apply(ctrl_q, set_mask, clr_mask);
    // A latched bus event always leaves the flag raised
    if (hw_flag_set) ctrl_d[FLAG_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/sbus_evt_latch.sv
module sbus_evt_latch
  import sbus_regs_pkg::*;
#(
  parameter logic [CODE_W-1:0] IDLE_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_q,
  input  logic              core_evt,
  input  logic [CODE_W-1:0] core_code,
  output logic              capture,
  output logic              pending,
  output logic [CODE_W-1:0] status_code
);
  logic [CODE_W-1:0] pend_code_q;

  assign capture = ~flag_q & (pending | core_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_code <= IDLE_CODE;
      pending     <= 1'b0;
      pend_code_q <= '0;
    end else begin
      if (capture) status_code <= pending ? pend_code_q : core_code;
      // A strobe that cannot be latched now is parked; newest wins
      if (core_evt && (flag_q || pending)) begin
        pending     <= 1'b1;
        pend_code_q <= core_code;
      end else if (capture) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbus_ctlstat_regs.sv
module sbus_ctlstat_regs
  import sbus_regs_pkg::*;
#(
  parameter int unsigned       FLAG_BIT  = 3,
  parameter logic [CODE_W-1:0] IDLE_CODE = 5'h1F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic [CODE_W-1:0]  core_code,
  input  logic               core_evt,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic               irq_o
);
  logic [DATA_W-1:0] ctrl_q, set_mask_w, clr_mask_w;
  logic [CODE_W-1:0] status_code_w;
  logic              capture_w, pending_w;

  sbus_host_dec dec_i (
    .host_sel    (host_sel),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .ctrl_q      (ctrl_q),
    .status_code (status_code_w),
    .set_mask    (set_mask_w),
    .clr_mask    (clr_mask_w),
    .host_rdata  (host_rdata)
  );

  sbus_ctl_bank #(.FLAG_BIT(FLAG_BIT)) bank_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_mask    (set_mask_w),
    .clr_mask    (clr_mask_w),
    .hw_flag_set (capture_w),
    .ctrl_q      (ctrl_q)
  );

  sbus_evt_latch #(.IDLE_CODE(IDLE_CODE)) evt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_q      (ctrl_q[FLAG_BIT]),
    .core_evt    (core_evt),
    .core_code   (core_code),
    .capture     (capture_w),
    .pending     (pending_w),
    .status_code (status_code_w)
  );

  assign ctrl_o = ctrl_q;
  assign irq_o  = ctrl_q[FLAG_BIT];
endmodule

// File: rtl/sbus_ctlstat_chk.sv
module sbus_ctlstat_chk
  import sbus_regs_pkg::*;
#(
  parameter int unsigned FLAG_BIT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_sel,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [DATA_W-1:0]  host_rdata,
  input logic [DATA_W-1:0]  ctrl_o,
  input logic               irq_o,
  input logic               capture_w,
  input logic               pending_w,
  input logic [CODE_W-1:0]  status_code_w
);
  logic wr_set, wr_clr, wr_ign, rd_stat;
  assign wr_set  = host_sel && host_we && host_addr == 2'd0;
  assign wr_clr  = host_sel && host_we && host_addr == 2'd2;
  assign wr_ign  = host_sel && host_we && (host_addr == 2'd1 || host_addr == 2'd3);
  assign rd_stat = host_sel && !host_we && host_addr == 2'd1;

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((ctrl_o & $past(host_wdata)) == $past(host_wdata)));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !capture_w) |=> ((ctrl_o & $past(host_wdata)) == '0));

  assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (host_rdata[VEC_SHIFT-1:0] == '0));

  assert_capture_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |=> irq_o);

  assert_frozen_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> (!irq_o || $stable(status_code_w)));

  assert_pending_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_w && !irq_o) |=> irq_o);

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ign && !capture_w) |=> ($stable(ctrl_o) && $stable(status_code_w)));

  assert_clr_vs_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && host_wdata[FLAG_BIT] && capture_w) |=> irq_o);
endmodule

bind sbus_ctlstat_regs sbus_ctlstat_chk #(.FLAG_BIT(FLAG_BIT)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_sel      (host_sel),
  .host_we       (host_we),
  .host_addr     (host_addr),
  .host_wdata    (host_wdata),
  .host_rdata    (host_rdata),
  .ctrl_o        (ctrl_o),
  .irq_o         (irq_o),
  .capture_w     (capture_w),
  .pending_w     (pending_w),
  .status_code_w (status_code_w)
);

// File: tb/sbus_ctlstat_regs_tb.sv
module sbus_ctlstat_regs_tb_top;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;
  // {addr[1:0], wdata[7:0], expected control[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'h81, 8'h81},   // R2 set
    {2'd0, 8'h14, 8'h95},   // R2 set, old bits kept
    {2'd2, 8'h01, 8'h94},   // R3 clear one bit
    {2'd2, 8'h00, 8'h94},   // R3 clear nothing
    {2'd1, 8'hFF, 8'h94},   // R9 status write ignored
    {2'd3, 8'hFF, 8'h94},   // R9 spare write ignored
    {2'd0, 8'h00, 8'h94},   // R2 set nothing
    {2'd2, 8'hF7, 8'h00}    // R3 clear all but flag
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0, host_we = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [4:0] core_code = '0;
  logic       core_evt = 1'b0;
  logic [7:0] ctrl_o;
  logic       irq_o;
  int         n_run = 0, n_fail = 0;
  logic       done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sbus_ctlstat_regs dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_code(core_code), .core_evt(core_evt), .ctrl_o(ctrl_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    #1 d = host_rdata;
    host_sel = 1'b0;
  endtask

  task automatic strobe(input logic [4:0] c);
    @(negedge clk);
    core_code = c; core_evt = 1'b1;
    @(posedge clk); #1;
    core_evt = 1'b0;
  endtask

  task automatic expect_state(input string req, input logic [7:0] exp_ctrl, input logic [7:0] exp_stat);
    logic [7:0] rd;
    check({req, " ctrl_o"}, ctrl_o, exp_ctrl);
    check({req, " irq_o (R8)"}, {7'd0, irq_o}, {7'd0, exp_ctrl[3]});
    host_read(2'd0, rd); check({req, " ctrl read"}, rd, exp_ctrl);
    host_read(2'd1, rd); check({req, " status read"}, rd, exp_stat);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_state("R1", 8'h00, 8'hF8);

    // R2 R3 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      host_write(VEC[i][17:16], VEC[i][15:8]);
      expect_state($sformatf("vec%0d R2/R3/R9", i), VEC[i][7:0], 8'hF8);
    end

    // R3 R9 read gating
    host_read(2'd2, rd); check("R3 clear port reads zero", rd, 8'h00);
    host_read(2'd3, rd); check("R9 spare reads zero", rd, 8'h00);
    host_write(2'd0, 8'h40);
    host_addr = 2'd0; host_sel = 1'b0; host_we = 1'b0;
    #1 check("R9 no read without sel", host_rdata, 8'h00);
    host_sel = 1'b1; host_we = 1'b1;
    #1 check("R9 no read data during write", host_rdata, 8'h00);
    host_sel = 1'b0; host_we = 1'b0;
    host_write(2'd2, 8'h40);

    // R5 capture with flag clear
    strobe(5'h01);
    expect_state("R5 capture", 8'h08, 8'h08);
    check("R4 low bits zero", {5'd0, host_rdata[2:0]}, 8'h00);

    // R6 frozen code, latest strobe kept pending
    strobe(5'h05);
    strobe(5'h0A);
    expect_state("R6 frozen", 8'h08, 8'h08);
    host_write(2'd1, 8'h00);
    expect_state("R9 status write while flag set", 8'h08, 8'h08);

    // R7 one-cycle gap then pending code latched
    host_write(2'd2, 8'h08);
    expect_state("R7 gap cycle", 8'h00, 8'h08);
    @(posedge clk); #1;
    expect_state("R7 pending latched", 8'h08, 8'h50);

    // R7 nothing pending: flag stays clear
    host_write(2'd2, 8'h08);
    repeat (2) @(posedge clk); #1;
    expect_state("R7 no spurious capture", 8'h00, 8'h50);

    // R10 clear write of flag coincident with capture
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = 2'd2; host_wdata = 8'h08;
    core_code = 5'h13; core_evt = 1'b1;
    @(posedge clk); #1;
    host_sel = 1'b0; host_we = 1'b0; core_evt = 1'b0;
    expect_state("R10 capture beats clear", 8'h08, 8'h98);

    // R10 software set of the flag keeps the code
    host_write(2'd2, 8'h08);
    @(posedge clk); #1;
    expect_state("R10 cleared", 8'h00, 8'h98);
    host_write(2'd0, 8'h08);
    expect_state("R10 software flag set", 8'h08, 8'h98);
    host_write(2'd2, 8'h08);

    // R1 reset in mid-operation
    host_write(2'd0, 8'hA5);
    strobe(5'h02);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    expect_state("R1 re-reset", 8'h00, 8'hF8);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule